// File: doc/BRIEF.md
# Instruction Prefetch Queue

This block keeps a short run of instruction words ready for an execute unit. It sits between the execute unit and a shared memory bus. When the execute side leaves the bus free, the block fetches the next sequential word and stores the word together with the address it came from. When the execute unit asks for its next instruction, that instruction is normally already waiting at the head of the queue. Data transfers from the execute side always win the bus. A new fetch starts only in a cycle when the execute side has signalled that it does not need the bus.

Two events change the flow of control: a resolved conditional branch whose condition holds, and an accepted interrupt. On either event the block drops every queued word and moves its fetch pointer to the supplied redirect address. A branch whose condition fails leaves the queue exactly as it was. A fetch that is still on the bus when a flush arrives completes on the bus as normal. Its returning word is thrown away.

Top module: `prefetch_queue`

## Requirements
- R1: While reset is high, and in the first cycle after it, `bus_req` and `ins_valid` are low.
- R2: A new bus request (a rising `bus_req`) begins only after a cycle in which `exec_bus_busy` was low. While `exec_bus_busy` stays high, no new request starts.
- R3: Instructions leave the queue in fetch order. Each word appears on `ins_word` together with the address it was fetched from on `ins_addr`. An instruction is taken when `ins_valid` and `ins_ready` are both high on a clock edge.
- R4: The first fetch after reset reads address `RESET_ADDR` (default 0). The fetch address then advances by 4 for each acknowledged fetch whose word is kept.
- R5: The queue holds at most `DEPTH` entries (default 4). With the consumer stalled, no new fetch is issued once the queue is full, even if the bus is idle.
- R6: A taken branch flushes the queue. A taken branch is `br_valid` high with `br_taken` high. `ins_valid` is low in the cycle after it, and fetching resumes at `redirect_addr`.
- R7: A resolved branch that is not taken has no effect on the queue. A branch is not taken when `br_valid` is high and `br_taken` is low. Queued entries remain, and no extra fetch is made.
- R8: An interrupt flushes the queue and redirects fetching in the same way as a taken branch. An interrupt is signalled by `irq_take` high.
- R9: If a request was outstanding when a flush occurred, its acknowledge is dropped. The first instruction delivered after the flush is the one at `redirect_addr`.
- R10: `ins_valid` is low whenever the queue is empty, including while the bus is held busy after a flush.
- R11: Once raised, `bus_req` stays high with `bus_addr` unchanged until the cycle in which `bus_ack` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | output | 1 | Fetch request, held until acknowledged |
| bus_addr | output | AW | Address of the outstanding fetch |
| bus_ack | input | 1 | Fetch completes this cycle |
| bus_rdata | input | DW | Fetched word, valid with `bus_ack` |
| exec_bus_busy | input | 1 | Execute side claims the bus; blocks new fetches |
| ins_valid | output | 1 | Head instruction available |
| ins_ready | input | 1 | Execute unit takes the head instruction |
| ins_word | output | DW | Head instruction word |
| ins_addr | output | AW | Address of the head instruction |
| br_valid | input | 1 | A conditional branch is resolved this cycle |
| br_taken | input | 1 | The resolved branch condition held |
| irq_take | input | 1 | An interrupt is accepted this cycle |
| redirect_addr | input | AW | New fetch address for a flush |

## Verification
A scoreboard compares every instruction that leaves the block against an independently computed list of expected addresses, each with its expected word. Stalling the consumer until the queue fills shows whether the queue stops fetching at its depth. A later drain shows whether the stored order and addresses are correct. Taken branches, interrupts and not-taken branches are applied while the queue is full, so that a flush that is too aggressive, or one that is missed, appears as a wrong next address. A slow bus with a flush applied while a request is outstanding separates dropping a late word from enqueuing it. A bus-busy pattern that toggles in a repeating cycle tests whether new requests start only in free cycles.

// File: rtl/pfq_pkg.sv
package pfq_pkg;

  // Bus-side fetch control state
  typedef enum logic [1:0] {
    FS_IDLE  = 2'd0,  // no request on the bus
    FS_WAIT  = 2'd1,  // request outstanding, word will be kept
    FS_STALE = 2'd2   // request outstanding, word will be dropped
  } fetch_state_t;

endpackage

// File: rtl/pfq_fetch.sv
module pfq_fetch #(
  parameter int AW         = 32,
  parameter int STEP       = 4,
  parameter logic [AW-1:0] RESET_ADDR = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          exec_busy,
  input  logic          room,
  input  logic          flush,
  input  logic [AW-1:0] redirect,
  input  logic          bus_ack,
  output logic          bus_req,
  output logic [AW-1:0] bus_addr,
  output logic          push,
  output logic [AW-1:0] push_addr
);
  import pfq_pkg::*;

  fetch_state_t  state;
  logic [AW-1:0] pf_addr;
  logic [AW-1:0] req_addr;
  logic          issue;

  assign issue     = (state == FS_IDLE) && !flush && !exec_busy && room;
  assign push      = (state == FS_WAIT) && bus_ack && !flush;
  assign push_addr = req_addr;
  assign bus_req   = (state != FS_IDLE);
  assign bus_addr  = req_addr;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= FS_IDLE;
      pf_addr  <= RESET_ADDR;
      req_addr <= RESET_ADDR;
    end else begin
      unique case (state)
        FS_IDLE: begin
          if (flush) begin
            pf_addr <= redirect;
          end else if (issue) begin
            req_addr <= pf_addr;
            state    <= FS_WAIT;
          end
        end
        FS_WAIT: begin
          if (bus_ack) begin
            pf_addr <= flush ? redirect : pf_addr + AW'(STEP);
            state   <= FS_IDLE;
          end else if (flush) begin
            pf_addr <= redirect;
            state   <= FS_STALE;
          end
        end
        FS_STALE: begin
          if (flush) pf_addr <= redirect;
          if (bus_ack) state <= FS_IDLE;
        end
        default: state <= FS_IDLE;
      endcase
    end
  end

  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr)));

  // R2
  req_start_free_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_req) |-> $past(!exec_busy));

  // R4
  addr_step_chk: assert property (@(posedge clk) disable iff (rst)
    push |=> (pf_addr == $past(pf_addr) + AW'(STEP)));

endmodule

// File: rtl/pfq_store.sv
module pfq_store #(
  parameter int DW    = 32,
  parameter int AW    = 32,
  parameter int DEPTH = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          push,
  input  logic [DW-1:0] push_word,
  input  logic [AW-1:0] push_addr,
  input  logic          pop,
  output logic          nonempty,
  output logic          has_room,
  output logic          full,
  output logic [DW-1:0] head_word,
  output logic [AW-1:0] head_addr
);
  logic [DW-1:0]    mem_word [DEPTH];
  logic [AW-1:0]    mem_addr [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
  logic [LVL_W-1:0] level;

  // Pointer wrap: free-running for power-of-two depths, compare otherwise
  generate
    if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
      assign wr_nxt = wr_ptr + PTR_W'(1);
      assign rd_nxt = rd_ptr + PTR_W'(1);
    end else begin : g_wrap
      assign wr_nxt = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + PTR_W'(1);
      assign rd_nxt = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + PTR_W'(1);
    end
  endgenerate

  // Storage array without reset so it maps onto distributed RAM
  always_ff @(posedge clk) begin
    if (push) begin
      mem_word[wr_ptr] <= push_word;
      mem_addr[wr_ptr] <= push_addr;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (push) wr_ptr <= wr_nxt;
      if (pop)  rd_ptr <= rd_nxt;
      unique case ({push, pop})
        2'b10:   level <= level + LVL_W'(1);
        2'b01:   level <= level - LVL_W'(1);
        default: level <= level;
      endcase
    end
  end

  assign nonempty  = (level != '0);
  assign full      = (level == LVL_W'(DEPTH));
  assign has_room  = !full;
  assign head_word = mem_word[rd_ptr];
  assign head_addr = mem_addr[rd_ptr];

  // R6
  flush_empty_chk: assert property (@(posedge clk) disable iff (rst)
    clear |=> !nonempty);

  // R10
  pop_nonempty_chk: assert property (@(posedge clk) disable iff (rst)
    pop |-> nonempty);

endmodule

// File: rtl/prefetch_queue.sv
module prefetch_queue #(
  parameter int DW    = 32,
  parameter int AW    = 32,
  parameter int DEPTH = 4,
  parameter int STEP  = 4,
  parameter logic [AW-1:0] RESET_ADDR = '0
) (
  input  logic          clk,
  input  logic          rst,
  output logic          bus_req,
  output logic [AW-1:0] bus_addr,
  input  logic          bus_ack,
  input  logic [DW-1:0] bus_rdata,
  input  logic          exec_bus_busy,
  output logic          ins_valid,
  input  logic          ins_ready,
  output logic [DW-1:0] ins_word,
  output logic [AW-1:0] ins_addr,
  input  logic          br_valid,
  input  logic          br_taken,
  input  logic          irq_take,
  input  logic [AW-1:0] redirect_addr
);
  logic          flush;
  logic          push, pop;
  logic [AW-1:0] push_addr;
  logic          room, full;

  // A failed branch condition is not a flush
  assign flush = (br_valid && br_taken) || irq_take;
  assign pop   = ins_valid && ins_ready && !flush;

  pfq_fetch #(
    .AW(AW), .STEP(STEP), .RESET_ADDR(RESET_ADDR)
  ) u_fetch (
    .clk       (clk),
    .rst       (rst),
    .exec_busy (exec_bus_busy),
    .room      (room),
    .flush     (flush),
    .redirect  (redirect_addr),
    .bus_ack   (bus_ack),
    .bus_req   (bus_req),
    .bus_addr  (bus_addr),
    .push      (push),
    .push_addr (push_addr)
  );

  pfq_store #(
    .DW(DW), .AW(AW), .DEPTH(DEPTH)
  ) u_store (
    .clk       (clk),
    .rst       (rst),
    .clear     (flush),
    .push      (push),
    .push_word (bus_rdata),
    .push_addr (push_addr),
    .pop       (pop),
    .nonempty  (ins_valid),
    .has_room  (room),
    .full      (full),
    .head_word (ins_word),
    .head_addr (ins_addr)
  );

  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    push |-> (!full || pop));

endmodule

// File: tb/prefetch_queue_test.sv
module prefetch_queue_test;
  localparam int DW = 32;
  localparam int AW = 32;
  localparam int DEPTH = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_req;
  logic [AW-1:0] bus_addr;
  logic          bus_ack = 1'b0;
  logic [DW-1:0] bus_rdata = '0;
  logic          exec_bus_busy = 1'b1;
  logic          ins_valid;
  logic          ins_ready = 1'b0;
  logic [DW-1:0] ins_word;
  logic [AW-1:0] ins_addr;
  logic          br_valid = 1'b0;
  logic          br_taken = 1'b0;
  logic          irq_take = 1'b0;
  logic [AW-1:0] redirect_addr = '0;

  int checks = 0;
  int errors = 0;
  int acks = 0;
  int lat = 1;
  int popped = 0;
  int req_busy_viol = 0;
  int hold_viol = 0;
  string cur_tag = "R3";
  logic [AW-1:0] exp_q[$];

  always #4 clk = ~clk;  // 125 MHz

  prefetch_queue #(.DW(DW), .AW(AW), .DEPTH(DEPTH)) uut (.*);

  function automatic logic [DW-1:0] mem_word(input logic [AW-1:0] a);
    return ~a ^ 32'h1234_5678;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic expect_from(input logic [AW-1:0] a);
    exp_q.delete();
    for (int i = 0; i < 64; i++) exp_q.push_back(a + AW'(4 * i));
  endtask

  task automatic do_flush(input bit use_irq, input logic [AW-1:0] a);
    if (use_irq) irq_take = 1'b1;
    else begin br_valid = 1'b1; br_taken = 1'b1; end
    redirect_addr = a;
    cyc(1);
    irq_take = 1'b0; br_valid = 1'b0; br_taken = 1'b0;
    expect_from(a);
  endtask

  // Bus model: acknowledges after lat cycles of request
  int bcnt = 0;
  always @(posedge clk) begin
    #1;
    if (bus_req && !bus_ack) begin
      bcnt++;
      if (bcnt >= lat) begin
        bus_ack = 1'b1; bus_rdata = mem_word(bus_addr); bcnt = 0; acks++;
      end
    end else begin
      bus_ack = 1'b0;
    end
  end

  // Monitor: scoreboard pops and protocol observation
  logic prev_req = 1'b0, prev_ack = 1'b0, prev_busy = 1'b1;
  logic [AW-1:0] prev_addr = '0;
  always @(negedge clk) begin
    if (!rst) begin
      if (ins_valid && ins_ready && !((br_valid && br_taken) || irq_take)) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, cur_tag, ins_addr, 32'hFFFF_FFFF);
        end else begin
          logic [AW-1:0] e;
          e = exp_q.pop_front();
          chk(ins_addr == e, {cur_tag, " R4 addr"}, ins_addr, e);
          chk(ins_word == mem_word(e), {cur_tag, " R3 word"}, ins_word, mem_word(e));
          popped++;
        end
      end
      if (bus_req && !prev_req && prev_busy) req_busy_viol++;
      if (prev_req && !prev_ack && (!bus_req || bus_addr != prev_addr)) hold_viol++;
    end
    prev_req = bus_req; prev_ack = bus_ack; prev_busy = exec_bus_busy; prev_addr = bus_addr;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=%0d expected=0", 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int p0;
    int a0;
    cyc(3);
    // R1: reset state
    chk(!bus_req, "R1 bus_req", 32'(bus_req), 0);
    chk(!ins_valid, "R1 ins_valid", 32'(ins_valid), 0);
    rst = 1'b0;
    expect_from('0);
    #0;
    chk(!bus_req && !ins_valid, "R1 after release", {30'b0, bus_req, ins_valid}, 0);
    // R2: busy bus blocks fetch
    cyc(10);
    chk(acks == 0 && !bus_req, "R2 busy blocks", 32'(acks), 0);
    chk(!ins_valid, "R10 empty", 32'(ins_valid), 0);
    // R5: fill with stalled consumer
    exec_bus_busy = 1'b0;
    cyc(60);
    chk(acks == DEPTH, "R5 fetch count", 32'(acks), DEPTH);
    chk(!bus_req, "R5 no req when full", 32'(bus_req), 0);
    chk(ins_valid, "R5 valid when full", 32'(ins_valid), 1);
    // R7: not-taken branch
    br_valid = 1'b1; br_taken = 1'b0; redirect_addr = 32'h0000_0900;
    cyc(1);
    br_valid = 1'b0;
    cyc(10);
    chk(acks == DEPTH, "R7 no refetch", 32'(acks), DEPTH);
    chk(ins_valid, "R7 queue kept", 32'(ins_valid), 1);
    // R3/R4: drain in order
    cur_tag = "R7"; p0 = popped;
    ins_ready = 1'b1;
    cyc(40);
    chk(popped - p0 >= 8, "R3 drained", 32'(popped - p0), 8);
    // R2: toggling busy while streaming
    cur_tag = "R2";
    for (int i = 0; i < 45; i++) begin
      exec_bus_busy = (i % 3) != 0;
      cyc(1);
    end
    exec_bus_busy = 1'b0;
    // R6: taken branch
    ins_ready = 1'b0;
    cyc(20);
    do_flush(1'b0, 32'h0000_1000);
    chk(!ins_valid, "R6 valid low after flush", 32'(ins_valid), 0);
    cur_tag = "R6"; p0 = popped;
    cyc(40); ins_ready = 1'b1; cyc(20);
    chk(popped - p0 >= 4, "R6 delivered", 32'(popped - p0), 4);
    // R8: interrupt
    ins_ready = 1'b0;
    cyc(20);
    do_flush(1'b1, 32'h0000_2000);
    chk(!ins_valid, "R8 valid low after flush", 32'(ins_valid), 0);
    cur_tag = "R8"; p0 = popped;
    cyc(40); ins_ready = 1'b1; cyc(20);
    chk(popped - p0 >= 4, "R8 delivered", 32'(popped - p0), 4);
    // R9: flush while a slow request is outstanding
    ins_ready = 1'b0; lat = 5;
    do_flush(1'b0, 32'h0000_3000);
    for (int i = 0; i < 20 && !bus_req; i++) cyc(1);
    chk(bus_req, "R9 request pending", 32'(bus_req), 1);
    a0 = acks;
    do_flush(1'b1, 32'h0000_4000);
    cur_tag = "R9"; p0 = popped;
    cyc(80);
    chk(acks - a0 == DEPTH + 1, "R9 stale plus refill", 32'(acks - a0), DEPTH + 1);
    ins_ready = 1'b1; cyc(60);
    chk(popped - p0 >= 4, "R9 delivered", 32'(popped - p0), 4);
    // R10: empty with busy bus
    exec_bus_busy = 1'b1;
    cyc(10);
    do_flush(1'b0, 32'h0000_5000);
    cyc(10);
    chk(!ins_valid, "R10 valid low while empty", 32'(ins_valid), 0);
    chk(!bus_req, "R2 no fetch while busy", 32'(bus_req), 0);
    exec_bus_busy = 1'b0;
    cur_tag = "R10";
    cyc(60);
    // Protocol observations
    chk(req_busy_viol == 0, "R2 request start", 32'(req_busy_viol), 0);
    chk(hold_viol == 0, "R11 request hold", 32'(hold_viol), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule